// File: doc/BRIEF.md
# Paging Mode Control Registers

This block keeps the paging-related bits of three architectural control registers: the main control register (`ctl0`), the feature control register (`ctl4`) and the extended-feature register (`feat`). Software-side writes arrive on a single write port. Each write names a target register and carries 64 bits of data, and the block judges it against the cross-register mode-transition rules before it commits anything. A legal write replaces the implemented bits of the target register. An illegal write leaves every register as it was and raises a one-cycle general-protection fault.

From the stored bits the block decodes the active paging mode. It also produces the effective write-protect, large-page, global-page and no-execute enables that the translation logic consumes. A read-only long-mode-active bit is derived from the stored bits and never stored itself. A combinational read port returns the image of any register.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset every implemented bit is zero, the mode is no-paging (code 0), all effective enables are low and no fault is signalled.
- R2: Register select codes are 0 = `ctl0`, 1 = `ctl4`, 2 = `feat`, 3 = none. Implemented bits are: `ctl0` bit 0 protection-enable, bit 16 write-protect, bit 31 paging-enable; `ctl4` bit 4 large-page, bit 5 address-extension, bit 7 global-page; `feat` bit 8 long-mode-enable, bit 11 no-execute-enable. Every other bit reads as zero, and select 3 reads as zero.
- R3: Bit 10 of `feat` reads as paging-enable AND long-mode-enable at all times, and the value written to bit 10 has no effect.
- R4: The mode output is 0 when paging is off, 1 (32-bit) when paging is on and address-extension is off, 2 (extended-address) when paging and address-extension are on and long-mode-enable is off, and 3 (4-level long mode) when all three are on.
- R5: A `feat` write that would change long-mode-enable while paging is on faults.
- R6: A `ctl0` write that turns paging on while address-extension is 0 and long-mode-enable is 1 faults.
- R7: A `ctl4` write that clears address-extension while paging and long-mode-enable are both on faults.
- R8: A `ctl0` write whose data has paging-enable set and protection-enable clear faults.
- R9: The effective write-protect and global-page enables are the stored bits gated by paging-enable. Effective large-page is active only in mode 1. Effective no-execute is active only in modes 2 and 3.
- R10: A faulting write changes no register. In the cycle after its clock edge, fault is high for one cycle with vector 13 and error code 0. With no fault, vector and code are 0.
- R11: A write with select 3 changes no register and raises no fault.
- R12: A legal write updates the target register at the clock edge it is sampled on, and the mode, enables and read-back reflect the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 2 | Read select |
| rd_data_o | output | 64 | Read-back image of the selected register |
| mode_o | output | 2 | Decoded paging mode |
| eff_wp_o | output | 1 | Effective write-protect |
| eff_pse_o | output | 1 | Effective large-page enable |
| eff_pge_o | output | 1 | Effective global-page enable |
| eff_nxe_o | output | 1 | Effective no-execute enable |
| lma_o | output | 1 | Long-mode-active status |
| fault_o | output | 1 | General-protection fault pulse |
| fault_vec_o | output | 8 | Fault vector |
| fault_code_o | output | 32 | Fault error code |

## Verification
A rejection and a mode change can fall in the same cycle. When writes come back to back, the fault pulse from a rejected write is visible while the next write, which may be legal, commits and shifts the mode. One `ctl0` write can also break the protection-enable rule and the long-mode ordering rule at once. The bench provokes both with directed sequences and with dense random writes on every cycle. On each clock it compares the pulse, the mode, the enables and the read-back against a behavioural model that applies the rules in order. A merged or mistimed fault therefore shows up as a mismatch in the cycle where it occurs.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned XLEN = 64;

  localparam int unsigned C0_PE  = 0;
  localparam int unsigned C0_WP  = 16;
  localparam int unsigned C0_PG  = 31;
  localparam int unsigned C4_PSE = 4;
  localparam int unsigned C4_PAE = 5;
  localparam int unsigned C4_PGE = 7;
  localparam int unsigned FE_LME = 8;
  localparam int unsigned FE_LMA = 10;
  localparam int unsigned FE_NXE = 11;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_P32   = 2'd1,
    MODE_PEXT  = 2'd2,
    MODE_LONG4 = 2'd3
  } pg_mode_e;

  typedef enum logic [1:0] {
    SEL_CTL0 = 2'd0,
    SEL_CTL4 = 2'd1,
    SEL_FEAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pe;
    logic wp;
    logic pg;
    logic pse;
    logic pae;
    logic pge;
    logic lme;
    logic nxe;
  } ctl_state_t;
endpackage

// File: rtl/pmc_legality.sv
module pmc_legality
  import pmc_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  ctl_state_t        cur_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctl_state_t        cand_o,
  output logic              commit_o,
  output logic              fault_o
);
  logic flt_pe, flt_order, flt_pae_clr, flt_lme_chg, hit;
  ctl_state_t cand;

  always_comb begin
    cand        = cur_i;
    hit         = 1'b0;
    flt_pe      = 1'b0;
    flt_order   = 1'b0;
    flt_pae_clr = 1'b0;
    flt_lme_chg = 1'b0;
    if (wr_en_i) begin
      unique case (reg_sel_e'(wr_sel_i))
        SEL_CTL0: begin
          hit      = 1'b1;
          cand.pe  = wr_data_i[C0_PE];
          cand.wp  = wr_data_i[C0_WP];
          cand.pg  = wr_data_i[C0_PG];
          flt_pe    = cand.pg && !cand.pe;
          // paging turned on with long mode requested but no address extension
          flt_order = cand.pg && !cur_i.pg && !cur_i.pae && cur_i.lme;
        end
        SEL_CTL4: begin
          hit      = 1'b1;
          cand.pse = wr_data_i[C4_PSE];
          cand.pae = wr_data_i[C4_PAE];
          cand.pge = wr_data_i[C4_PGE];
          flt_pae_clr = cur_i.pg && cur_i.lme && !cand.pae;
        end
        SEL_FEAT: begin
          hit      = 1'b1;
          cand.lme = wr_data_i[FE_LME];
          cand.nxe = wr_data_i[FE_NXE];
          flt_lme_chg = cur_i.pg && (cand.lme != cur_i.lme);
        end
        default: ;
      endcase
    end
  end

  assign fault_o  = flt_pe | flt_order | flt_pae_clr | flt_lme_chg;
  assign commit_o = hit & ~fault_o;
  assign cand_o   = cand;

  logic unused_data;
  assign unused_data = ^wr_data_i;
endmodule

// File: rtl/pmc_state.sv
module pmc_state
  import pmc_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned CODE_W    = 32,
  parameter int unsigned FAULT_VEC = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_state_t        cand_i,
  input  logic              commit_i,
  input  logic              fault_i,
  output ctl_state_t        state_o,
  output logic              fault_o,
  output logic [VEC_W-1:0]  fault_vec_o,
  output logic [CODE_W-1:0] fault_code_o
);
  localparam logic [VEC_W-1:0] VecVal = VEC_W'(FAULT_VEC);

  ctl_state_t state_q;
  logic       fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_i;
      if (commit_i) state_q <= cand_i;
    end
  end

  assign state_o      = state_q;
  assign fault_o      = fault_q;
  assign fault_vec_o  = fault_q ? VecVal : '0;
  assign fault_code_o = '0;
endmodule

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
  import pmc_pkg::*;
(
  input  ctl_state_t state_i,
  output pg_mode_e   mode_o,
  output logic       eff_wp_o,
  output logic       eff_pse_o,
  output logic       eff_pge_o,
  output logic       eff_nxe_o,
  output logic       lma_o
);
  always_comb begin
    if (!state_i.pg)       mode_o = MODE_NONE;
    else if (!state_i.pae) mode_o = MODE_P32;
    else if (!state_i.lme) mode_o = MODE_PEXT;
    else                   mode_o = MODE_LONG4;
  end

  assign eff_wp_o  = state_i.pg & state_i.wp;
  assign eff_pge_o = state_i.pg & state_i.pge;
  assign eff_pse_o = (mode_o == MODE_P32) & state_i.pse;
  assign eff_nxe_o = ((mode_o == MODE_PEXT) | (mode_o == MODE_LONG4)) & state_i.nxe;
  assign lma_o     = state_i.pg & state_i.lme;
endmodule

// File: rtl/pmc_readback.sv
module pmc_readback
  import pmc_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN
) (
  input  ctl_state_t        state_i,
  input  logic              lma_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] img_c0, img_c4, img_fe;

  always_comb begin
    img_c0 = '0;
    img_c4 = '0;
    img_fe = '0;
    img_c0[C0_PE]  = state_i.pe;
    img_c0[C0_WP]  = state_i.wp;
    img_c0[C0_PG]  = state_i.pg;
    img_c4[C4_PSE] = state_i.pse;
    img_c4[C4_PAE] = state_i.pae;
    img_c4[C4_PGE] = state_i.pge;
    img_fe[FE_LME] = state_i.lme;
    img_fe[FE_LMA] = lma_i;
    img_fe[FE_NXE] = state_i.nxe;
    unique case (reg_sel_e'(rd_sel_i))
      SEL_CTL0: rd_data_o = img_c0;
      SEL_CTL4: rd_data_o = img_c4;
      SEL_FEAT: rd_data_o = img_fe;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned DATA_W    = XLEN,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned CODE_W    = 32,
  parameter int unsigned FAULT_VEC = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        mode_o,
  output logic              eff_wp_o,
  output logic              eff_pse_o,
  output logic              eff_pge_o,
  output logic              eff_nxe_o,
  output logic              lma_o,
  output logic              fault_o,
  output logic [VEC_W-1:0]  fault_vec_o,
  output logic [CODE_W-1:0] fault_code_o
);
  ctl_state_t state_w, cand_w;
  logic       commit_w, fault_w;
  pg_mode_e   mode_w;

  pmc_legality #(.DATA_W(DATA_W)) u_legal (
    .cur_i    (state_w),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .cand_o   (cand_w),
    .commit_o (commit_w),
    .fault_o  (fault_w)
  );

  pmc_state #(.VEC_W(VEC_W), .CODE_W(CODE_W), .FAULT_VEC(FAULT_VEC)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cand_i      (cand_w),
    .commit_i    (commit_w),
    .fault_i     (fault_w),
    .state_o     (state_w),
    .fault_o     (fault_o),
    .fault_vec_o (fault_vec_o),
    .fault_code_o(fault_code_o)
  );

  pmc_mode_decode u_dec (
    .state_i  (state_w),
    .mode_o   (mode_w),
    .eff_wp_o (eff_wp_o),
    .eff_pse_o(eff_pse_o),
    .eff_pge_o(eff_pge_o),
    .eff_nxe_o(eff_nxe_o),
    .lma_o    (lma_o)
  );

  pmc_readback #(.DATA_W(DATA_W)) u_rd (
    .state_i  (state_w),
    .lma_i    (lma_o),
    .rd_sel_i (rd_sel_i),
    .rd_data_o(rd_data_o)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/pmc_ctrl_chk.sv
module pmc_ctrl_chk
  import pmc_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned CODE_W    = 32,
  parameter int unsigned FAULT_VEC = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input ctl_state_t        state_i,
  input logic [1:0]        mode_i,
  input logic              eff_wp_i,
  input logic              eff_pse_i,
  input logic              eff_pge_i,
  input logic              eff_nxe_i,
  input logic              lma_i,
  input logic              fault_i,
  input logic [VEC_W-1:0]  fault_vec_i,
  input logic [CODE_W-1:0] fault_code_i
);
  AST_LMA_IMPLIES_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lma_i |-> (mode_i == MODE_LONG4)); // R3
  AST_PG_NEEDS_PE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i.pg |-> state_i.pe); // R8
  AST_LME_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i.pg && $past(state_i.pg)) |-> $stable(state_i.lme)); // R5
  AST_NO_P32_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i.pg && !state_i.pae) |-> !state_i.lme); // R6
  AST_PAE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i.pg && state_i.lme) |-> state_i.pae); // R7
  AST_EFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NONE) |-> !(eff_wp_i | eff_pse_i | eff_pge_i | eff_nxe_i)); // R9
  AST_FAULT_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> $past(wr_en_i)); // R10
  AST_FAULT_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> (fault_vec_i == VEC_W'(FAULT_VEC) && fault_code_i == '0)); // R10
  AST_FAULT_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> $stable(state_i)); // R10
endmodule

bind pmc_ctrl pmc_ctrl_chk #(.VEC_W(VEC_W), .CODE_W(CODE_W), .FAULT_VEC(FAULT_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .state_i     (state_w),
  .mode_i      (mode_o),
  .eff_wp_i    (eff_wp_o),
  .eff_pse_i   (eff_pse_o),
  .eff_pge_i   (eff_pge_o),
  .eff_nxe_i   (eff_nxe_o),
  .lma_i       (lma_o),
  .fault_i     (fault_o),
  .fault_vec_i (fault_vec_o),
  .fault_code_i(fault_code_o)
);

// File: tb/pmc_ctrl_tb.sv
`timescale 1ns/1ps
module pmc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic [1:0]  mode;
  logic        eff_wp, eff_pse, eff_pge, eff_nxe, lma, fault;
  logic [7:0]  fvec;
  logic [31:0] fcode;

  always #2.5 clk = ~clk;

  pmc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .mode_o(mode), .eff_wp_o(eff_wp),
    .eff_pse_o(eff_pse), .eff_pge_o(eff_pge), .eff_nxe_o(eff_nxe), .lma_o(lma),
    .fault_o(fault), .fault_vec_o(fvec), .fault_code_o(fcode)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit chk_on = 0;

  // behavioural model: register images as plain 64-bit words
  logic [63:0] m_c0 = '0, m_c4 = '0, m_fe = '0;
  bit m_flt = 0;
  localparam logic [63:0] M0 = 64'h8001_0001, M4 = 64'h0000_00B0, MF = 64'h0000_0900;

  function automatic bit m_pg();  return m_c0[31]; endfunction
  function automatic bit m_lme(); return m_fe[8];  endfunction

  function automatic int m_mode();
    if (!m_c0[31]) return 0;
    if (!m_c4[5])  return 1;
    if (!m_fe[8])  return 2;
    return 3;
  endfunction

  function automatic logic [63:0] m_img(int s);
    case (s)
      0: return m_c0;
      1: return m_c4;
      2: return m_fe | ({63'd0, m_pg() & m_lme()} << 10);
      default: return 64'd0;
    endcase
  endfunction

  function automatic bit m_rej(int s, logic [63:0] d);
    case (s)
      0: return (d[31] && !d[0]) || (d[31] && !m_c0[31] && !m_c4[5] && m_fe[8]);
      1: return m_c0[31] && m_fe[8] && !d[5];
      2: return m_c0[31] && (d[8] != m_fe[8]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c0 = '0; m_c4 = '0; m_fe = '0; m_flt = 0;
    end else begin
      m_flt = 0;
      if (wr_en) begin
        m_flt = m_rej(int'(wr_sel), wr_data);
        if (!m_flt) begin
          case (wr_sel)
            2'd0: m_c0 = wr_data & M0;
            2'd1: m_c4 = wr_data & M4;
            2'd2: m_fe = wr_data & MF;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R4 mode", 64'(mode), 64'(m_mode()));
      chk("R3 lma", 64'(lma), 64'(m_pg() & m_lme()));
      chk("R9 eff_wp", 64'(eff_wp), 64'(m_pg() & m_c0[16]));
      chk("R9 eff_pge", 64'(eff_pge), 64'(m_pg() & m_c4[7]));
      chk("R9 eff_pse", 64'(eff_pse), 64'((m_mode() == 1) & m_c4[4]));
      chk("R9 eff_nxe", 64'(eff_nxe), 64'((m_mode() >= 2) & m_fe[11]));
      chk("R10 fault", 64'(fault), 64'(m_flt));
      chk("R10 vector", 64'(fvec), m_flt ? 64'd13 : 64'd0);
      chk("R10 code", 64'(fcode), 64'd0);
      chk("R2 readback", rd_data, m_img(int'(rd_sel)));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rb(input logic [1:0] s, input string tag, input logic [63:0] exp);
    rd_sel = s; #0.5;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", 64'(mode), 0);
    chk("R1 fault in reset", 64'(fault), 0);
    chk("R1 enables in reset", 64'({eff_wp, eff_pse, eff_pge, eff_nxe, lma}), 0);
    #1 rst_n = 1'b1;
    rb(2'd0, "R1 ctl0 reset", 0);
    rb(2'd1, "R1 ctl4 reset", 0);
    rb(2'd2, "R1 feat reset", 0);
    chk_on = 1;

    wr(2'd0, 64'hFFFF_FFFF_8000_0000);               // paging without protection
    chk("R8 fault", 64'(fault), 1);
    rb(2'd0, "R10 ctl0 unchanged", 0);
    wr(2'd0, 64'hFFFF_0000_0000_0001);
    rb(2'd0, "R2 ctl0 masked", 64'h1);
    wr(2'd2, 64'h0000_0000_0000_0500);               // LME plus written bit 10
    chk("R12 no fault", 64'(fault), 0);
    rb(2'd2, "R3 bit10 ignored", 64'h100);
    wr(2'd0, 64'h8000_0001);                         // paging on, long mode requested, no PAE
    chk("R6 fault", 64'(fault), 1);
    chk("R6 mode", 64'(mode), 0);
    wr(2'd1, 64'h20);
    wr(2'd0, 64'h8001_0001);
    chk("R4 long mode", 64'(mode), 3);
    rb(2'd2, "R3 lma set", 64'h500);
    wr(2'd1, 64'h0);
    chk("R7 fault", 64'(fault), 1);
    rb(2'd1, "R7 ctl4 kept", 64'h20);
    wr(2'd2, 64'h0);
    chk("R5 fault", 64'(fault), 1);
    rb(2'd2, "R5 feat kept", 64'h500);
    wr(2'd2, 64'h900);
    chk("R9 nxe long", 64'(eff_nxe), 1);
    wr(2'd3, '1);
    chk("R11 no fault", 64'(fault), 0);
    rb(2'd0, "R11 ctl0 kept", 64'h8001_0001);
    rb(2'd3, "R2 select 3 reads zero", 0);
    wr(2'd0, 64'h1);
    chk("R9 enables off", 64'({eff_wp, eff_pse, eff_pge, eff_nxe}), 0);
    wr(2'd2, 64'h800);
    wr(2'd1, 64'h90);
    wr(2'd0, 64'h8001_0001);
    chk("R4 32-bit mode", 64'(mode), 1);
    chk("R9 pse in 32-bit", 64'(eff_pse), 1);
    chk("R9 nxe off in 32-bit", 64'(eff_nxe), 0);
    wr(2'd1, 64'hB0);
    chk("R4 ext mode", 64'(mode), 2);
    chk("R9 pse off in ext", 64'(eff_pse), 0);
    chk("R9 nxe in ext", 64'(eff_nxe), 1);
    // same-cycle: rejected write then a legal one right after
    @(negedge clk); #1; wr_en = 1; wr_sel = 2'd2; wr_data = 64'h100;  // LME change while paging
    @(negedge clk); #1; wr_sel = 2'd0; wr_data = 64'h1;               // legal paging off
    chk("R10 pulse with next write", 64'(fault), 1);
    @(negedge clk); #1; wr_en = 0;
    chk("R10 pulse ends", 64'(fault), 0);
    chk("R12 mode after legal", 64'(mode), 0);

    repeat (4000) begin
      @(negedge clk); #1;
      wr_en   = 1'($urandom % 4 != 0);
      wr_sel  = 2'($urandom % 4);
      wr_data = {$urandom, $urandom};
      if ($urandom % 2 == 1) wr_data[8] = m_fe[8];
      if ($urandom % 2 == 1) wr_data[0] = 1'b1;
      rd_sel  = 2'($urandom % 4);
    end
    @(negedge clk); #1; wr_en = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule